// File: doc/BRIEF.md
# Shared Routing Switch Controller

This block decides where the head flit of each new packet leaves a five-port mesh router. Each input controller raises a request carrying the destination address of its packet. A rotating-priority arbiter picks one requester per clock cycle and acknowledges it in the same cycle. A single XY routing unit, shared by every input, maps the winner's destination to an output port. The winner's 3-bit input identifier is then written into a small queue that belongs to that output.

Every output port has its own queue. The queue head is shown to the crossbar as a valid flag plus an input identifier. The crossbar holds that binding for the whole packet. When the packet's last flit has left, the crossbar pulses a done line for that output, which removes the head entry. Requests for an output are therefore served in the order they won arbitration, and no arbiter is needed at the outputs.

Port identifiers are fixed codes: East 0, West 1, North 2, South 3, Local 4. The address is split in two halves. The upper half is the X coordinate and the lower half is the Y coordinate.

Top module: `route_switch_ctrl`

## Requirements
- R1: After reset, all queues are empty, so `route_vld` is 0. With no request present, `req_ack` is 0.
- R2: In any cycle, `req_ack` has at most one bit set. That bit belongs to an input whose `req_vld` is high, and it is set combinationally in the same cycle as the request.
- R3: The arbiter starts its search at a pointer. The pointer is 0 after reset. After a grant to input i, the next search starts at input (i+1) mod 5. The grant goes to the first requesting input found going upward with wrap-around.
- R4: Routing compares the destination X field (upper half) with the router's own X field first. Greater gives East (0) and smaller gives West (1). If X is equal, Y (lower half) decides: greater gives North (2) and smaller gives South (3). If both fields are equal, the result is Local (4).
- R5: On the clock edge that ends a grant, the winner's input identifier is appended to the queue of its computed output. It is visible on `route_vld`/`route_id` in the cycle after the grant.
- R6: Each queue is first-in first-out and holds up to 4 entries. A `route_done` pulse removes the head. A push and a pop on the same edge keep the order and the entry count correct.
- R7: While another input is still requesting, the input granted in one cycle is not granted again in the next cycle.
- R8: A queue never accepts a push while it is full, unless a pop happens on the same edge. Four simultaneous requesters for one output are all stored, with none lost.
- R9: A `route_done` pulse on an output whose queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 5 | Per-input routing request, held until acknowledged |
| req_addr | input | 5*ADDR_W | Destination address per input; input i uses bits [i*ADDR_W +: ADDR_W] |
| my_addr | input | ADDR_W | This router's own address, X in the upper half |
| req_ack | output | 5 | One-hot grant, combinational, for the request that wins this cycle |
| route_vld | output | 5 | Per-output flag that the queue holds at least one entry |
| route_id | output | 5*3 | Per-output head input identifier; output o uses bits [o*3 +: 3] |
| route_done | input | 5 | Per-output packet-finished pulse that removes the queue head |

## Verification
The assertions rely on a few assumptions about the inputs:
- A requester holds `req_vld` and its address steady until it sees its acknowledge.
- An input has at most one packet in flight, so it does not request again before its previous queue entry has been popped.
- No input sends a packet back out through its own port, so at most four inputs ever compete for one output.

The stimulus keeps within these limits. Requests are raised only for inputs that are not already pending. Addresses change only when an input is idle. In the sequences that fill a queue, only the four non-Local inputs target the Local output. An input re-requests only after its entry has been popped on the same edge.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  parameter int NPORT = 5;
  parameter int ID_W  = 3;

  typedef enum logic [ID_W-1:0] {
    PORT_EAST  = 3'd0,
    PORT_WEST  = 3'd1,
    PORT_NORTH = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_LOCAL = 3'd4
  } port_e;
endpackage

// File: rtl/rsc_arbiter.sv
module rsc_arbiter #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_vld
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;
  int            idx;

  // search from ptr_q upward with wrap-around; first requester wins
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_vld = 1'b0;
    idx     = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!gnt_vld && req[idx]) begin
        gnt_vld  = 1'b1;
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
      end
    end
  end

  always_comb begin
    if (gnt_idx == IW'(N-1)) ptr_d = '0;
    else                     ptr_d = gnt_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (gnt_vld) ptr_q <= ptr_d;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0)); // R2

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && ((req & ~gnt) != '0)) |=> ((gnt & $past(gnt)) == '0)); // R7
endmodule

// File: rtl/rsc_xy_route.sv
module rsc_xy_route import rsc_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] dest,
  input  logic [ADDR_W-1:0] own,
  output port_e             sel
);
  localparam int HALF = ADDR_W / 2;

  logic [HALF-1:0] dx, dy, ox, oy;

  assign dx = dest[ADDR_W-1:HALF];
  assign dy = dest[HALF-1:0];
  assign ox = own[ADDR_W-1:HALF];
  assign oy = own[HALF-1:0];

  always_comb begin
    if (dx > ox)      sel = PORT_EAST;
    else if (dx < ox) sel = PORT_WEST;
    else if (dy > oy) sel = PORT_NORTH;
    else if (dy < oy) sel = PORT_SOUTH;
    else              sel = PORT_LOCAL;
  end
endmodule

// File: rtl/rsc_out_queue.sv
module rsc_out_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         head_vld,
  output logic [W-1:0] head_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_ok;
  logic          full;

  assign pop_ok    = pop && (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign head_vld  = (cnt_q != '0);
  assign head_data = mem_q[rd_q];

  always_comb begin
    wr_d = (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + PW'(1);
    rd_d = (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + PW'(1);
    cnt_d = cnt_q;
    if (push && !pop_ok)      cnt_d = cnt_q + CW'(1);
    else if (!push && pop_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push)   wr_q <= wr_d;
      if (pop_ok) rd_q <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop)); // R8

  AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> head_vld); // R5

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !head_vld && !push) |=> !head_vld); // R9

  AST_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_vld && !push) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R6
endmodule

// File: rtl/route_switch_ctrl.sv
module route_switch_ctrl import rsc_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int QDEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        req_vld,
  input  logic [NPORT*ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0]       my_addr,
  output logic [NPORT-1:0]        req_ack,
  output logic [NPORT-1:0]        route_vld,
  output logic [NPORT*ID_W-1:0]   route_id,
  input  logic [NPORT-1:0]        route_done
);
  localparam int HALF = ADDR_W / 2;

  logic [NPORT-1:0]  gnt;
  logic [ID_W-1:0]   gnt_idx;
  logic              gnt_vld;
  logic [ADDR_W-1:0] win_addr;
  port_e             out_sel;

  rsc_arbiter #(.N(NPORT), .IW(ID_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_vld),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_vld (gnt_vld)
  );

  assign req_ack = gnt;

  always_comb begin
    win_addr = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (gnt[i]) win_addr = req_addr[i*ADDR_W +: ADDR_W];
    end
  end

  rsc_xy_route #(.ADDR_W(ADDR_W)) u_route (
    .dest (win_addr),
    .own  (my_addr),
    .sel  (out_sel)
  );

  for (genvar o = 0; o < NPORT; o++) begin : g_q
    logic q_push;
    assign q_push = gnt_vld && (out_sel == port_e'(o));

    rsc_out_queue #(.DEPTH(QDEPTH), .W(ID_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (gnt_idx),
      .pop       (route_done[o]),
      .head_vld  (route_vld[o]),
      .head_data (route_id[o*ID_W +: ID_W])
    );
  end

  AST_LOCAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && out_sel == PORT_LOCAL) |-> (win_addr == my_addr)); // R4

  AST_X_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && win_addr[ADDR_W-1:HALF] != my_addr[ADDR_W-1:HALF])
      |-> (out_sel == PORT_EAST || out_sel == PORT_WEST)); // R4

  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(route_vld & ~$past(route_vld)) <= 1); // R5
endmodule

// File: tb/route_switch_ctrl_bench.sv
`timescale 1ns/1ps
module route_switch_ctrl_bench;
  localparam int AW = 4;
  localparam int NP = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NP-1:0]  req_vld;
  logic [NP*AW-1:0] req_addr;
  logic [AW-1:0]  my_addr;
  logic [NP-1:0]  req_ack;
  logic [NP-1:0]  route_vld;
  logic [NP*3-1:0] route_id;
  logic [NP-1:0]  route_done;

  logic [AW-1:0]  da [NP];
  assign req_addr = {da[4], da[3], da[2], da[1], da[0]};

  always #4 clk = ~clk;

  route_switch_ctrl #(.ADDR_W(AW), .QDEPTH(4)) u_route_switch_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_addr   (req_addr),
    .my_addr    (my_addr),
    .req_ack    (req_ack),
    .route_vld  (route_vld),
    .route_id   (route_id),
    .route_done (route_done)
  );

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  int mq [NP][8];
  int mcnt [NP];
  int mptr;
  logic [NP-1:0] pend;
  logic [NP-1:0] prev_ack;
  bit prev_others;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int xy(input logic [AW-1:0] d, input logic [AW-1:0] own);
    int dx, dy, ox, oy;
    dx = int'(d[AW-1:AW/2]); dy = int'(d[AW/2-1:0]);
    ox = int'(own[AW-1:AW/2]); oy = int'(own[AW/2-1:0]);
    if (dx > ox) return 0;
    if (dx < ox) return 1;
    if (dy > oy) return 2;
    if (dy < oy) return 3;
    return 4;
  endfunction

  // one clock: drive at negedge, check grant, update model at posedge, check heads
  task automatic cyc(input logic [NP-1:0] done, input string tag);
    logic [NP-1:0] exp_g, act_g, ev, av;
    logic [NP*3-1:0] ei, ai;
    int win;
    req_vld = pend;
    route_done = done;
    #1;
    exp_g = '0; win = -1;
    for (int k = 0; k < NP; k++) begin
      int i;
      i = (mptr + k) % NP;
      if (win < 0 && pend[i]) win = i;
    end
    if (win >= 0) exp_g[win] = 1'b1;
    act_g = req_ack;
    chk(act_g == exp_g, {tag, " R2 R3 grant"}, int'(act_g), int'(exp_g));
    if (prev_ack != '0 && prev_others)
      chk(act_g != prev_ack, {tag, " R7 repeat grant"}, int'(act_g), 0);
    prev_ack = act_g;
    prev_others = ((pend & ~act_g) != '0);
    @(posedge clk);
    for (int o = 0; o < NP; o++) begin
      if (done[o] && mcnt[o] > 0) begin
        for (int j = 0; j < 7; j++) mq[o][j] = mq[o][j+1];
        mcnt[o]--;
      end
    end
    if (win >= 0) begin
      int r;
      r = xy(da[win], my_addr);
      mq[r][mcnt[r]] = win;
      mcnt[r]++;
      mptr = (win + 1) % NP;
    end
    pend = pend & ~act_g;
    @(negedge clk);
    ev = '0; ei = '0; ai = '0;
    for (int o = 0; o < NP; o++) begin
      ev[o] = (mcnt[o] > 0);
      if (mcnt[o] > 0) begin
        ei[o*3 +: 3] = 3'(mq[o][0]);
        ai[o*3 +: 3] = route_id[o*3 +: 3];
      end
    end
    av = route_vld;
    chk(av == ev, {tag, " R5 R6 head valid"}, int'(av), int'(ev));
    chk(ai == ei, {tag, " R5 R6 head id"}, int'(ai), int'(ei));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_vld = '0; route_done = '0; my_addr = '0;
    for (int i = 0; i < NP; i++) begin da[i] = '0; mcnt[i] = 0; end
    mptr = 0; pend = '0; prev_ack = '0; prev_others = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(route_vld == '0, "R1 reset queues empty", int'(route_vld), 0);
    chk(req_ack == '0, "R1 reset no grant", int'(req_ack), 0);
    @(negedge clk);

    // R4 exhaustive XY sweep, one request then pop
    for (int own = 0; own < 16; own++) begin
      for (int d = 0; d < 16; d++) begin
        int r;
        my_addr = 4'(own);
        da[1] = 4'(d);
        pend = 5'b00010;
        cyc('0, "R4 sweep push");
        r = xy(4'(d), 4'(own));
        chk(route_vld == (5'b1 << r), "R4 route port", int'(route_vld), 1 << r);
        cyc(route_vld, "R4 sweep pop");
      end
    end

    // R3 R7 arbitration under changing request patterns, popping every cycle
    my_addr = 4'b0101;
    for (int c = 0; c < 60; c++) begin
      logic [NP-1:0] nw;
      nw = 5'((c * 7 + 3) % 32) | ((c < 3) ? 5'b11111 : 5'b0);
      for (int i = 0; i < NP; i++) begin
        if (!pend[i] && nw[i]) begin
          da[i] = 4'((c * 3 + i * 5) % 16);
          pend[i] = 1'b1;
        end
      end
      cyc(5'b11111, "R3 rotate");
    end
    for (int c = 0; c < 4; c++) cyc(5'b11111, "R3 drain");

    // R6 R8 fill Local queue with four inputs, then push+pop, then drain
    for (int i = 0; i < 4; i++) da[i] = 4'b0101;
    pend = 5'b01111;
    for (int c = 0; c < 4; c++) cyc('0, "R8 fill");
    chk(mcnt[4] == 4 && route_vld[4], "R8 four stored", int'(route_vld), 5'b10000);
    begin
      int h;
      h = mq[4][0];
      pend[h] = 1'b1;
      cyc(5'b10000, "R6 push and pop");
    end
    chk(mcnt[4] == 4, "R6 count after push+pop", mcnt[4], 4);
    for (int c = 0; c < 4; c++) cyc(5'b10000, "R6 drain");
    chk(route_vld == '0, "R6 all drained", int'(route_vld), 0);

    // R9 done on empty queues ignored
    cyc(5'b11111, "R9 empty done");
    cyc(5'b11111, "R9 empty done");
    chk(route_vld == '0, "R9 still empty", int'(route_vld), 0);
    da[2] = 4'b0101;
    pend = 5'b00100;
    cyc('0, "R9 push after empty done");
    chk(route_vld == 5'b10000 && route_id[14:12] == 3'd2, "R9 single entry",
        int'(route_vld), 5'b10000);
    cyc(5'b10000, "R9 pop");
    cyc(5'b10000, "R9 second done ignored");
    chk(route_vld == '0, "R9 empty after extra done", int'(route_vld), 0);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule